// File: doc/BRIEF.md
# Serial Transmit Engine with Line Break and Half-Duplex Turnaround

This block turns bytes into an asynchronous serial stream. A byte offered on a ready/valid input is parked in a one-byte holding register. On the next bit strobe it goes out as a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. A single-cycle `bit_tick` strobe from an external baud generator paces every bit. The line idles high.

Two controls sit on top of the framer. A break control word forces the line low for as long as it is non-zero. A break request never cuts a character short: it takes effect at the next character boundary.

A half-duplex mode drives a transceiver direction output. The output switches to transmit as soon as there is work and stays there across back-to-back characters and breaks. It falls back to receive only after a programmable number of idle bit times (0 to 15). With half-duplex off, the output is held in transmit.

Top module: `utx_engine`

## Requirements
- R1: Each bit lasts from one `bit_tick` to the next. A frame is a start bit (0), then DATA_W data bits LSB first, then a parity bit when `par_en`=1, then one stop bit (1), or two when `stop_two`=1. The line is 1 when idle.
- R2: With `par_en`=1, the parity bit is the XOR of the data bits XOR `par_odd`. So `par_odd`=0 gives even parity and `par_odd`=1 gives odd parity.
- R3: A byte is taken when `in_valid` and `in_ready` are both high. It goes out starting at the next `bit_tick`. If the following byte is already held when a frame's last stop bit ends, its start bit follows with no idle bit in between.
- R4: While `brk_ctl` is non-zero, `txd` is held low. The low level begins at a character boundary, so a character in flight completes through its stop bits first. `txd` returns high at the first `bit_tick` after `brk_ctl` is zero again.
- R5: `in_ready` is low while `brk_ctl` is non-zero. A byte already held when a break is requested waits, and is sent intact once the break ends.
- R6: With `hd_en`=0, `drv_en` is 1 from the second cycle after reset onward and never falls.
- R7: With `hd_en`=1, `drv_en` is 1 in the cycle after a byte is accepted, before the start bit is on the line. It stays 1 through every bit of the frame.
- R8: With `hd_en`=1 and delay D = `turn_dly`, `drv_en` falls at the (D+1)-th `bit_tick` after the line returns to idle. The line returns to idle at the tick ending the last stop bit, or the tick ending a break.
- R9: A byte accepted while the turnaround count runs cancels the count. `drv_en` stays 1 and the count restarts after the new frame.
- R10: `drv_en` stays 1 for the whole of a break.
- R11: During reset, `txd`=1, `drv_en`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe marking each bit boundary |
| in_data | input | DATA_W | Byte to transmit |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding register can take a byte |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| stop_two | input | 1 | 1 selects two stop bits |
| brk_ctl | input | BRK_W | Non-zero requests a line break |
| hd_en | input | 1 | Half-duplex direction control enable |
| turn_dly | input | DLY_W | Idle bit times before releasing the driver |
| txd | output | 1 | Serial output line |
| drv_en | output | 1 | Transceiver direction, 1 = transmit |

## Verification
The start bit of an accepted byte appears at the first `bit_tick` edge after the accepting edge. `drv_en` rises on the accepting edge itself. A break starts at the tick that ends a frame, or at the next tick when the line is idle. The release of `drv_en` lands on the (D+1)-th tick after the line returns high.

The bench numbers every tick edge. It samples `txd` and `drv_en` on the falling clock edge that follows each tick. It compares the recorded tick index of each falling `drv_en` with the index at which the monitor saw the line go idle. Frame contents are matched against a queue that the driver fills on each accepted byte.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_BRK   = 3'd5
  } ser_state_t;
endpackage

// File: rtl/utx_serializer.sv
module utx_serializer
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_two,
  input  logic              brk_req,
  output logic              txd,
  output logic              busy,
  output logic              pending
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  ser_state_t        st_q;
  logic [DATA_W-1:0] hold_q, sh_q;
  logic              hold_vld;
  logic [IDX_W-1:0]  idx_q;
  logic              par_q, stop_q, txd_q;
  logic              accept, frame_end, launch;

  assign in_ready  = !hold_vld && !brk_req;
  assign accept    = in_valid && in_ready;
  assign frame_end = bit_tick && (st_q == S_STOP) && (!stop_two || stop_q);
  assign launch    = bit_tick && !brk_req && hold_vld &&
                     ((st_q == S_IDLE) || frame_end);

  // one-byte holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld <= 1'b0;
      hold_q   <= '0;
    end else if (accept) begin
      hold_vld <= 1'b1;
      hold_q   <= in_data;
    end else if (launch) begin
      hold_vld <= 1'b0;
    end
  end

  // bit sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      txd_q  <= 1'b1;
      sh_q   <= '0;
      idx_q  <= '0;
      par_q  <= 1'b0;
      stop_q <= 1'b0;
    end else if (bit_tick) begin
      case (st_q)
        S_IDLE: begin
          if (brk_req) begin
            st_q  <= S_BRK;
            txd_q <= 1'b0;
          end else if (hold_vld) begin
            st_q  <= S_START;
            txd_q <= 1'b0;
            sh_q  <= hold_q;
            par_q <= (^hold_q) ^ par_odd;
          end
        end
        S_START: begin
          st_q  <= S_DATA;
          txd_q <= sh_q[0];
          sh_q  <= sh_q >> 1;
          idx_q <= '0;
        end
        S_DATA: begin
          if (idx_q == LAST_IDX) begin
            stop_q <= 1'b0;
            if (par_en) begin
              st_q  <= S_PAR;
              txd_q <= par_q;
            end else begin
              st_q  <= S_STOP;
              txd_q <= 1'b1;
            end
          end else begin
            txd_q <= sh_q[0];
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
          end
        end
        S_PAR: begin
          st_q   <= S_STOP;
          txd_q  <= 1'b1;
          stop_q <= 1'b0;
        end
        S_STOP: begin
          if (stop_two && !stop_q) begin
            stop_q <= 1'b1;
          end else if (brk_req) begin
            st_q  <= S_BRK;
            txd_q <= 1'b0;
          end else if (hold_vld) begin
            st_q  <= S_START;
            txd_q <= 1'b0;
            sh_q  <= hold_q;
            par_q <= (^hold_q) ^ par_odd;
          end else begin
            st_q  <= S_IDLE;
            txd_q <= 1'b1;
          end
        end
        S_BRK: begin
          if (!brk_req) begin
            st_q  <= S_IDLE;
            txd_q <= 1'b1;
          end
        end
        default: begin
          st_q  <= S_IDLE;
          txd_q <= 1'b1;
        end
      endcase
    end
  end

  assign txd     = txd_q;
  assign busy    = (st_q != S_IDLE);
  assign pending = hold_vld;

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_START) |-> !txd_q);

  // R4
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == S_BRK) && $past(st_q == S_BRK)) |-> !txd_q);

  // R4
  brk_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == S_BRK) |-> ($past(st_q) == S_IDLE || $past(st_q) == S_STOP));

  // R3
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_vld && !launch) |=> (hold_vld && hold_q == $past(hold_q)));
endmodule

// File: rtl/utx_turnaround.sv
module utx_turnaround #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             hd_en,
  input  logic [DLY_W-1:0] turn_dly,
  input  logic             activity,
  output logic             drv_en
);
  logic [DLY_W-1:0] cnt_q;
  logic             drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= 1'b0;
      cnt_q <= '0;
    end else if (!hd_en || activity) begin
      drv_q <= 1'b1;
      cnt_q <= '0;
    end else if (drv_q && bit_tick) begin
      if (cnt_q == turn_dly) begin
        drv_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign drv_en = drv_q;

  // R8
  release_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_q) |-> $past(bit_tick && hd_en && !activity));

  // R6
  fixed_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !hd_en |=> drv_q);
endmodule

// File: rtl/utx_engine.sv
module utx_engine
  import utx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BRK_W  = 8,
  parameter int DLY_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_two,
  input  logic [BRK_W-1:0]  brk_ctl,
  input  logic              hd_en,
  input  logic [DLY_W-1:0]  turn_dly,
  output logic              txd,
  output logic              drv_en
);
  logic brk_req, ser_busy, ser_pending, activity;

  assign brk_req  = |brk_ctl;
  assign activity = (in_valid && in_ready) || ser_pending || ser_busy || brk_req;

  utx_serializer #(.DATA_W(DATA_W)) ser_i (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .stop_two (stop_two),
    .brk_req  (brk_req),
    .txd      (txd),
    .busy     (ser_busy),
    .pending  (ser_pending)
  );

  utx_turnaround #(.DLY_W(DLY_W)) dir_i (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .hd_en    (hd_en),
    .turn_dly (turn_dly),
    .activity (activity),
    .drv_en   (drv_en)
  );

  // R7
  busy_drv_chk: assert property (@(posedge clk) disable iff (rst)
    ser_busy |-> drv_en);

  // R10
  brk_drv_chk: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> drv_en);
endmodule

// File: tb/utx_engine_tb_top.sv
module utx_engine_tb_top;
  localparam int DW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       par_en = 1'b0, par_odd = 1'b0, stop_two = 1'b0;
  logic [7:0] brk_ctl = '0;
  logic       hd_en = 1'b0;
  logic [3:0] turn_dly = '0;
  logic       in_ready, txd, drv_en;

  utx_engine #(.DATA_W(DW), .BRK_W(8), .DLY_W(4)) dut_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .par_en(par_en),
    .par_odd(par_odd), .stop_two(stop_two), .brk_ctl(brk_ctl),
    .hd_en(hd_en), .turn_dly(turn_dly), .txd(txd), .drv_en(drv_en)
  );

  always #4 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    if (tdiv == 3) begin tdiv <= 0; bit_tick <= 1'b1; end
    else begin tdiv <= tdiv + 1; bit_tick <= 1'b0; end
  end

  int tick_n = 0;
  bit tick_hit = 1'b0;
  always @(posedge clk) begin
    tick_hit <= bit_tick;
    if (bit_tick) tick_n <= tick_n + 1;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct { logic [7:0] d; logic pe; logic po; logic s2; } frm_t;
  frm_t exp_q[$];
  frm_t cur;
  int   m_st = 0, bcnt = 0, scnt = 0, last_end_tick = -100, gap0 = 0;
  int   brk_len = 0, brk_done = 0, frames = 0, sent = 0;
  logic [7:0] rx = '0;
  bit   drv_ok = 1'b1;
  bit   prev_drv = 1'b0, fall_on_tick = 1'b0;
  int   fall_cnt = 0, fall_tick = 0;

  // monitor: one line sample per bit time, right after each tick edge
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_drv && !drv_en) begin
        fall_cnt++; fall_tick = tick_n; fall_on_tick = tick_hit;
      end
      prev_drv = drv_en;
      if (tick_hit) begin
        case (m_st)
          0: if (!txd) begin
               if (brk_ctl != 0) begin
                 m_st = 4; brk_len = 1; drv_ok = drv_en;
               end else if (exp_q.size() > 0) begin
                 cur = exp_q.pop_front();
                 if (tick_n == last_end_tick) gap0++;
                 m_st = 1; bcnt = 0; rx = '0; drv_ok = drv_en;
               end else begin
                 chk(1'b0, "R1", "unexpected start bit", 0, 1);
               end
             end
          1: begin
               rx[bcnt] = txd; bcnt++; drv_ok &= drv_en; scnt = 0;
               if (bcnt == DW) m_st = cur.pe ? 2 : 3;
             end
          2: begin
               chk(txd == ((^cur.d) ^ cur.po), "R2", "parity bit",
                   txd, (^cur.d) ^ cur.po);
               drv_ok &= drv_en; m_st = 3;
             end
          3: begin
               chk(txd == 1'b1, "R1", "stop bit", txd, 1);
               drv_ok &= drv_en; scnt++;
               if (!cur.s2 || scnt == 2) begin
                 chk(rx == cur.d, "R1", "data byte", rx, cur.d);
                 chk(drv_ok, "R7", "drv_en high through frame", drv_ok, 1);
                 frames++; last_end_tick = tick_n + 1; m_st = 0;
               end
             end
          4: begin
               if (!txd) begin
                 brk_len++; drv_ok &= drv_en;
               end else begin
                 chk(drv_ok, "R10", "drv_en high through break", drv_ok, 1);
                 brk_done++; last_end_tick = tick_n; m_st = 0;
               end
             end
          default: m_st = 0;
        endcase
      end
    end
  end

  // driver: offers a byte, records it in the scoreboard once taken
  task automatic send(input logic [7:0] d);
    frm_t f;
    in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    f.d = d; f.pe = par_en; f.po = par_odd; f.s2 = stop_two;
    exp_q.push_back(f); sent++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0 || m_st != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic hd_run(input int d);
    int base;
    turn_dly = 4'(d); hd_en = 1'b1;
    repeat (80) @(negedge clk);
    chk(drv_en == 1'b0, "R8", "released while idle", drv_en, 0);
    base = fall_cnt;
    send(8'h69);
    chk(drv_en == 1'b1, "R7", "drv_en set right after accept", drv_en, 1);
    chk(txd == 1'b1, "R7", "start bit not yet on line", txd, 1);
    wait_idle();
    repeat (4 * (d + 4)) @(negedge clk);
    chk(fall_cnt == base + 1, "R8", "single release", fall_cnt, base + 1);
    chk(fall_on_tick && (fall_tick - last_end_tick == d + 1), "R8",
        "release tick offset", fall_tick - last_end_tick, d + 1);
  endtask

  bit done = 1'b0;

  initial begin
    int base, bd;
    repeat (4) @(negedge clk);
    chk(txd === 1'b1, "R11", "txd in reset", txd, 1);
    chk(drv_en === 1'b0, "R11", "drv_en in reset", drv_en, 0);
    chk(in_ready === 1'b1, "R11", "in_ready in reset", in_ready, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(drv_en == 1'b1, "R6", "drv_en with half duplex off", drv_en, 1);

    // R1 R3: plain frames, back to back
    send(8'hA5); send(8'h3C); send(8'h00); send(8'hFF);
    wait_idle();
    chk(gap0 == 3, "R3", "frames with no idle bit between", gap0, 3);
    chk(frames == 4, "R1", "frames decoded", frames, 4);

    // R2: even, odd, two stop bits
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h5A); send(8'h07); wait_idle();
    par_odd = 1'b1;
    send(8'h5A); send(8'h80); wait_idle();
    stop_two = 1'b1;
    send(8'hC3); send(8'h01); wait_idle();
    par_en = 1'b0; par_odd = 1'b0;
    send(8'h96); wait_idle();
    stop_two = 1'b0;
    repeat (8) @(negedge clk);

    // R6: long idle with half duplex off
    base = fall_cnt;
    repeat (200) @(negedge clk);
    chk(fall_cnt == base && drv_en == 1'b1, "R6", "driver never released",
        fall_cnt - base, 0);

    // R8: delays 0, 5, 15
    hd_run(0);
    hd_run(5);
    hd_run(15);

    // R9: byte during count cancels release
    turn_dly = 4'd10;
    base = fall_cnt;
    send(8'h11); wait_idle();
    repeat (16) @(negedge clk);
    chk(drv_en == 1'b1, "R9", "still driving during count", drv_en, 1);
    send(8'h22); wait_idle();
    chk(fall_cnt == base, "R9", "no release between frames", fall_cnt, base);
    repeat (56) @(negedge clk);
    chk(fall_cnt == base + 1, "R9", "release after second frame", fall_cnt, base + 1);
    chk(fall_tick - last_end_tick == 11, "R9", "count restarted",
        fall_tick - last_end_tick, 11);

    // R4 R5 R10: break during a frame with a byte held
    turn_dly = 4'd3;
    base = fall_cnt; bd = brk_done;
    send(8'hB7);
    while (m_st != 1) @(negedge clk);
    send(8'h4E);
    brk_ctl = 8'h40;
    @(negedge clk);
    chk(in_ready == 1'b0, "R5", "ready low with break requested", in_ready, 0);
    while (m_st != 4) @(negedge clk);
    chk(exp_q.size() == 1, "R5", "held byte waits during break", exp_q.size(), 1);
    repeat (24) @(negedge clk);
    chk(txd == 1'b0, "R4", "line low during break", txd, 0);
    chk(drv_en == 1'b1, "R10", "driving during break", drv_en, 1);
    chk(in_ready == 1'b0, "R5", "ready low during break", in_ready, 0);
    brk_ctl = '0;
    wait_idle();
    chk(brk_done == bd + 1, "R4", "break observed", brk_done, bd + 1);
    chk(brk_len >= 6, "R4", "break length in bits", brk_len, 6);
    chk(fall_cnt == base, "R10", "no release around break", fall_cnt, base);
    repeat (40) @(negedge clk);
    chk(fall_cnt == base + 1, "R8", "release after break and byte", fall_cnt, base + 1);
    chk(fall_tick - last_end_tick == 4, "R8", "release offset D=3",
        fall_tick - last_end_tick, 4);

    // R4: break from idle, half duplex off
    hd_en = 1'b0;
    repeat (8) @(negedge clk);
    brk_ctl = 8'h01;
    repeat (8) @(negedge clk);
    chk(txd == 1'b0, "R4", "break from idle", txd, 0);
    chk(in_ready == 1'b0, "R5", "ready low in idle break", in_ready, 0);
    brk_ctl = '0;
    repeat (8) @(negedge clk);
    chk(txd == 1'b1, "R4", "line high after clear", txd, 1);
    chk(in_ready == 1'b1, "R5", "ready back after clear", in_ready, 1);
    send(8'hE1); wait_idle();
    chk(frames == sent, "R1", "all frames decoded", frames, sent);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule